// File: doc/BRIEF.md
# Two-View Report Coincidence Finder

This block decides whether one calorimeter cluster earns a trigger accept. Two independent pattern-matching views each produce a stream of match reports. Each report carries a 64-bit header that counts symbol cycles from the start of the input stream, and upstream logic strips the bitmap part away before the header reaches this block. For each cluster the block first collects every view A header into a small associative store. It then streams the view B headers past that store. A view B header finds a partner when a stored view A header is exactly one symbol cycle earlier, that is, equal to the view B value minus one.

On the first such partner the block pulses accept together with done and stops judging that cluster. It still drains the rest of the view B stream without reacting. When view B ends with no partner, done pulses alone. A start pulse clears the store and opens the next cluster. A user drives the start pulse, then the view A stream with a last marker, then the view B stream with a last marker, and reads one done pulse per cluster.

Top module: `coinc_finder`

## Requirements
- R1: Out of reset, accept, done, a_ready and b_ready are all low, and the block waits for a cluster start.
- R2: A clu_start pulse while idle empties the store and opens the view A phase, in which a_ready is high while the store has room. A clu_start pulse during a cluster in progress is ignored and the stored headers are kept.
- R3: Every view A header accepted before the view A last marker, and the one carrying it, is kept in the store and is available to the view B lookup.
- R4: b_ready stays low until the view A record carrying a_last has been accepted, so no view B header is examined before all view A headers are stored.
- R5: A view B header H is a coincidence when some stored view A header equals H-1. Accept and done then pulse high together for exactly one cycle, in the cycle after that view B handshake.
- R6: A view A header equal to H, or equal to H+1, is not a coincidence for a view B header H.
- R7: A view B header of value zero never gives accept, even when the store holds the all-ones header. The subtraction does not wrap.
- R8: After the first coincidence, the remaining view B headers of the cluster are still taken (b_ready high) but raise neither done nor accept. After b_last the block is idle with both ready outputs low.
- R9: If the view B record carrying b_last finds no coincidence, done pulses for one cycle, in the cycle after that handshake, and accept stays low.
- R10: The store holds DEPTH headers. Once DEPTH headers are held, a_ready is low and no further view A header is taken.
- R11: Headers stored for one cluster cannot match view B headers of any later cluster.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clu_start | input | 1 | Start of a new cluster, taken only while idle |
| a_valid | input | 1 | View A header valid |
| a_ready | output | 1 | View A header can be taken |
| a_last | input | 1 | Marks the final view A header of the cluster |
| a_hdr | input | HDR_W (64) | View A report offset header |
| b_valid | input | 1 | View B header valid |
| b_ready | output | 1 | View B header can be taken |
| b_last | input | 1 | Marks the final view B header of the cluster |
| b_hdr | input | HDR_W (64) | View B report offset header |
| accept | output | 1 | One-cycle trigger accept pulse |
| done | output | 1 | One-cycle end-of-decision pulse |

## Verification
A stale or missing valid bit in the store shows up as a wrong accept in the cycle right after the view B handshake it affects. The bench therefore samples accept and done after every single view B header, not only at the end of a cluster. A phase register stuck in the wrong state shows at once on a_ready or b_ready, which the bench reads before each handshake. An error in the lag arithmetic, such as equality matching, an offset of +1, or wraparound at zero, changes the verdict on vectors built to sit exactly on those boundaries. A store that is not cleared shows up in a follow-on cluster built to match only against the previous cluster's headers.

// File: rtl/coinc_pkg.sv
package coinc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LOAD  = 2'd1,
      PH_SCAN  = 2'd2,
      PH_DRAIN = 2'd3
   } phase_t;

endpackage

// File: rtl/coinc_key_store.sv
module coinc_key_store #(
   parameter int KEY_W = 64,
   parameter int DEPTH = 16,
   parameter int LAG   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             wr_en,
   input  logic [KEY_W-1:0] wr_key,
   input  logic [KEY_W-1:0] probe_key,
   output logic             full,
   output logic             hit
);
   localparam int PTR_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
   localparam logic [KEY_W-1:0] LAG_K    = KEY_W'(LAG);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("coinc_key_store: DEPTH must be at least 2");
      end
      if (LAG < 1) begin : g_bad_lag
         $error("coinc_key_store: LAG must be at least 1");
      end
      if (KEY_W < 8) begin : g_bad_width
         $error("coinc_key_store: KEY_W must be at least 8");
      end
   endgenerate

   logic [PTR_W-1:0] fill_q;
   logic [DEPTH-1:0] vld_q;
   logic [KEY_W-1:0] key_q [DEPTH];
   logic [DEPTH-1:0] cmp_vec;
   logic [KEY_W-1:0] target;
   logic             probe_ok;

   assign full     = (fill_q == FULL_CNT);
   assign probe_ok = (probe_key >= LAG_K);
   assign target   = probe_key - LAG_K;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         fill_q <= '0;
      end else if (wr_en && !full) begin
         fill_q <= fill_q + 1'b1;
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < DEPTH; gi++) begin : g_entry
         logic sel;
         assign sel = wr_en && !full && (fill_q == PTR_W'(gi));

         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               vld_q[gi] <= 1'b0;
            end else if (sel) begin
               vld_q[gi] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (sel) begin
               key_q[gi] <= wr_key;
            end
         end

         assign cmp_vec[gi] = vld_q[gi] && (key_q[gi] == target);
      end
   endgenerate

   assign hit = probe_ok && (|cmp_vec);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full);  // R10

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (fill_q == '0) && (vld_q == '0));  // R11

endmodule

// File: rtl/coinc_seq.sv
module coinc_seq
   import coinc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clu_start,
   input  logic a_valid,
   input  logic a_last,
   input  logic b_valid,
   input  logic b_last,
   input  logic full,
   input  logic hit,
   output logic a_ready,
   output logic b_ready,
   output logic store_clear,
   output logic store_wr,
   output logic accept,
   output logic done
);
   phase_t st_q, st_d;
   logic   acc_d, done_d;
   logic   a_fire, b_fire;

   assign a_ready     = (st_q == PH_LOAD) && !full;
   assign b_ready     = (st_q == PH_SCAN) || (st_q == PH_DRAIN);
   assign a_fire      = a_valid && a_ready;
   assign b_fire      = b_valid && b_ready;
   assign store_clear = (st_q == PH_IDLE) && clu_start;
   assign store_wr    = a_fire;

   always_comb begin
      st_d   = st_q;
      acc_d  = 1'b0;
      done_d = 1'b0;
      unique case (st_q)
         PH_IDLE: begin
            if (clu_start) st_d = PH_LOAD;
         end
         PH_LOAD: begin
            if (a_fire && a_last) st_d = PH_SCAN;
         end
         PH_SCAN: begin
            if (b_fire) begin
               if (hit) begin
                  acc_d  = 1'b1;
                  done_d = 1'b1;
                  st_d   = b_last ? PH_IDLE : PH_DRAIN;
               end else if (b_last) begin
                  done_d = 1'b1;
                  st_d   = PH_IDLE;
               end
            end
         end
         PH_DRAIN: begin
            if (b_fire && b_last) st_d = PH_IDLE;
         end
         default: st_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= PH_IDLE;
         accept <= 1'b0;
         done   <= 1'b0;
      end else begin
         st_q   <= st_d;
         accept <= acc_d;
         done   <= done_d;
      end
   end

   AST_ACCEPT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> done);  // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);  // R8

   AST_NO_B_BEFORE_A: assert property (@(posedge clk) disable iff (!rst_n)
      a_ready |-> !b_ready);  // R4

   AST_WRITE_ONLY_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
      store_wr |-> !b_ready && !done);  // R3

endmodule

// File: rtl/coinc_finder.sv
module coinc_finder #(
   parameter int HDR_W = 64,
   parameter int DEPTH = 16,
   parameter int LAG   = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clu_start,
   input  logic             a_valid,
   output logic             a_ready,
   input  logic             a_last,
   input  logic [HDR_W-1:0] a_hdr,
   input  logic             b_valid,
   output logic             b_ready,
   input  logic             b_last,
   input  logic [HDR_W-1:0] b_hdr,
   output logic             accept,
   output logic             done
);
   logic store_clear, store_wr, full, hit;

   coinc_key_store #(
      .KEY_W (HDR_W),
      .DEPTH (DEPTH),
      .LAG   (LAG)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (store_clear),
      .wr_en     (store_wr),
      .wr_key    (a_hdr),
      .probe_key (b_hdr),
      .full      (full),
      .hit       (hit)
   );

   coinc_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .clu_start   (clu_start),
      .a_valid     (a_valid),
      .a_last      (a_last),
      .b_valid     (b_valid),
      .b_last      (b_last),
      .full        (full),
      .hit         (hit),
      .a_ready     (a_ready),
      .b_ready     (b_ready),
      .store_clear (store_clear),
      .store_wr    (store_wr),
      .accept      (accept),
      .done        (done)
   );

   AST_ZERO_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (b_valid && b_ready && (b_hdr == '0)) |=> !accept);  // R7

   AST_ACCEPT_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> $past(b_valid && b_ready));  // R5

endmodule

// File: tb/coinc_finder_tb.sv
module coinc_finder_tb;
   localparam int W = 64;
   localparam int D = 4;

   typedef struct packed {
      logic [W-1:0] a0, a1, a2;
      int           na;
      logic [W-1:0] b0, b1, b2;
      int           nb;
      int           hit_at;   // -1: no coincidence
   } row_t;

   localparam int NROW = 7;
   localparam row_t VEC [NROW] = '{
      '{64'd100, 64'd200, 64'd300, 3, 64'd50, 64'd201, 64'd400, 3, 1},   // R5
      '{64'd10, 64'd20, 64'd0, 2, 64'd10, 64'd20, 64'd0, 2, -1},         // R6 R9
      '{64'd5, 64'd0, 64'd0, 1, 64'd4, 64'd6, 64'd0, 2, 1},              // R6
      '{64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 1, 64'd0, 64'd1, 64'd0, 2, -1}, // R7
      '{64'd7, 64'd8, 64'd9, 3, 64'd10, 64'd9, 64'd8, 3, 0},             // R8
      '{64'h8000_0000_0000_0000, 64'd0, 64'd0, 1, 64'h8000_0000_0000_0001, 64'd0, 64'd0, 1, 0}, // R3
      '{64'd0, 64'd0, 64'd0, 1, 64'd1, 64'd0, 64'd0, 1, 0}               // R3
   };

   logic clk = 1'b0, rst_n = 1'b0, clu_start = 1'b0;
   logic a_valid = 1'b0, a_last = 1'b0, b_valid = 1'b0, b_last = 1'b0;
   logic [W-1:0] a_hdr = '0, b_hdr = '0;
   logic a_ready, b_ready, accept, done;
   int   tests = 0, fails = 0;
   bit   finished = 0;

   always #2 clk = ~clk;

   coinc_finder #(.HDR_W(W), .DEPTH(D), .LAG(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .clu_start(clu_start),
      .a_valid(a_valid), .a_ready(a_ready), .a_last(a_last), .a_hdr(a_hdr),
      .b_valid(b_valid), .b_ready(b_ready), .b_last(b_last), .b_hdr(b_hdr),
      .accept(accept), .done(done));

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic start_cluster();
      clu_start = 1'b1;
      @(negedge clk);
      clu_start = 1'b0;
   endtask

   task automatic send_a(input logic [W-1:0] h, input bit last);
      a_valid = 1'b1; a_hdr = h; a_last = last;
      #1;
      while (!a_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      a_valid = 1'b0; a_last = 1'b0;
   endtask

   task automatic send_b(input logic [W-1:0] h, input bit last, output logic acc, output logic dn);
      b_valid = 1'b1; b_hdr = h; b_last = last;
      #1;
      while (!b_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      acc = accept; dn = done;
      b_valid = 1'b0; b_last = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         fails++; tests++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic acc, dn;
      logic [W-1:0] bv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!accept && !done && !a_ready && !b_ready, "R1",
            {accept, done, a_ready, b_ready}, 0);

      for (int r = 0; r < NROW; r++) begin
         start_cluster();
         check(a_ready == 1'b1, "R2", a_ready, 1);
         for (int i = 0; i < VEC[r].na; i++)
            send_a(i == 0 ? VEC[r].a0 : (i == 1 ? VEC[r].a1 : VEC[r].a2), i == VEC[r].na - 1);
         for (int i = 0; i < VEC[r].nb; i++) begin
            bit is_last;
            bit e_acc, e_done;
            bv = (i == 0) ? VEC[r].b0 : (i == 1 ? VEC[r].b1 : VEC[r].b2);
            is_last = (i == VEC[r].nb - 1);
            e_acc  = (i == VEC[r].hit_at);
            e_done = e_acc || (VEC[r].hit_at < 0 && is_last);
            send_b(bv, is_last, acc, dn);
            // R5 R6 R7 R8 R9 per-header verdict
            check(acc == e_acc, "R5/R6/R7 accept", acc, e_acc);
            check(dn == e_done, "R8/R9 done", dn, e_done);
         end
         check(!a_ready && !b_ready, "R8 idle", {a_ready, b_ready}, 0);
      end

      // R4: view B held off during loading
      start_cluster();
      b_valid = 1'b1; b_hdr = 64'd33; #1;
      check(b_ready == 1'b0, "R4", b_ready, 0);
      b_valid = 1'b0;
      send_a(64'd500, 1'b0);
      // R2: start pulse mid-cluster ignored, stored header kept
      start_cluster();
      check(a_ready == 1'b1, "R2 ignored start", a_ready, 1);
      send_a(64'd600, 1'b1);
      #1;
      check(b_ready == 1'b1, "R4 open", b_ready, 1);
      send_b(64'd501, 1'b1, acc, dn);
      check(acc && dn, "R2 R3 kept", {acc, dn}, 3);

      // R11: previous cluster headers gone
      start_cluster();
      send_a(64'd1000, 1'b1);
      send_b(64'd5, 1'b1, acc, dn);
      start_cluster();
      send_a(64'd1, 1'b1);
      send_b(64'd1001, 1'b1, acc, dn);
      check(!acc && dn, "R11", {acc, dn}, 1);

      // R10: store full
      start_cluster();
      for (int i = 0; i < D; i++) send_a(64'd70 + 64'(i), 1'b0);
      #1;
      check(a_ready == 1'b0, "R10 full", a_ready, 0);
      a_valid = 1'b1; a_hdr = 64'd99; a_last = 1'b1;
      repeat (3) @(negedge clk);
      check(a_ready == 1'b0 && b_ready == 1'b0, "R10 held", {a_ready, b_ready}, 0);
      a_valid = 1'b0; a_last = 1'b0;

      // R1 reset from a stuck cluster
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!accept && !done && !a_ready && !b_ready, "R1 rereset",
            {accept, done, a_ready, b_ready}, 0);

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule